// File: doc/BRIEF.md
# Eight-Point Two-Dimensional Inverse Integer Transform

This block turns an 8x8 block of signed 16-bit transform coefficients into an 8x8 block of signed 16-bit residuals. It runs two one-dimensional passes through a single shared 8-point unit, handling one column or one row each clock. The first pass works down the columns with a fixed rounding shift. Its saturated results go into an internal 8x8 buffer. The second pass reads that buffer back by rows and uses a shift that depends on the selected sample bit depth.

Each 8-point transform has two halves. The even half is a 4-point butterfly on inputs 0, 2, 4 and 6. The odd half multiplies inputs 1, 3, 5 and 7 by a fixed 4x4 matrix of weights. The even half is kept at full accumulator precision until it is added to or subtracted from the odd half. Rounding and saturation happen only after that combination.

A client drives all 64 coefficients and the bit-depth select, then pulses `start`. Sixteen clock edges later `done` pulses once, and the residual bus holds the complete result.

Top module: `idct8_2d`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `done` is low and `res_out` is all zeros.
- R2: The even half forms e0 = 64(x0+x4) + 83x2 + 36x6, e1 = 64(x0−x4) + 36x2 − 83x6, e2 = 64(x0−x4) − 36x2 + 83x6, and e3 = 64(x0+x4) − 83x2 − 36x6. None of these is rounded before it is combined.
- R3: The odd half forms o0 = 89x1+75x3+50x5+18x7, o1 = 75x1−18x3−89x5−50x7, o2 = 50x1−89x3+18x5+75x7, and o3 = 18x1−50x3+75x5−89x7.
- R4: For k in 0..3, output k is e[k]+o[k] and output 7−k is e[k]−o[k], each rounded and saturated.
- R5: The column pass computes (v + 64) >> 7, an arithmetic shift on at least 32 bits.
- R6: The row pass shifts by 12 with offset 2048 when `bd_sel`=0 (8-bit samples) and by 10 with offset 512 when `bd_sel`=1 (10-bit samples).
- R7: Every pass clamps its results to the range −32768..32767.
- R8: Coefficient (row r, column c) sits at `coef_in[16*(8r+c) +: 16]`, and residual (r, c) sits at the same position in `res_out`. The columns are transformed first, then the rows.
- R9: `done` is high for exactly one cycle, on the 16th rising edge after the edge that samples `start`. `res_out` changes only during the row pass and holds its value from then on.
- R10: A `start` pulse that arrives while a block is in progress is ignored. Coefficients are sampled only at the edge that accepts `start`.
- R11: `bd_sel` is sampled with the accepted `start`. Changing it later has no effect on the block in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block when idle |
| bd_sel | input | 1 | 0: 8-bit samples, 1: 10-bit samples |
| coef_in | input | 1024 | 64 signed 16-bit coefficients, row-major |
| res_out | output | 1024 | 64 signed 16-bit residuals, row-major |
| done | output | 1 | One-cycle pulse when `res_out` is complete |

## Verification
The assertions check the sequencing on every cycle:
- `done` lasts a single cycle and always follows the last row step.
- The column pass hands over to the row pass at index zero.
- The latched coefficients and bit-depth select stay fixed while a block is in progress.
- The residual register changes only during the row pass.

The arithmetic can only be shown by the bench's scenarios. These compare the full block against an integer model:
- impulses at every one of the 64 positions, at both bit depths;
- DC-only blocks with known closed-form results;
- random blocks;
- saturating corner patterns.

The same scenarios also show that a restart attempt in the middle of a block has no effect.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

    parameter int N  = 8;
    parameter int W  = 16;
    parameter int AW = 32;

    localparam int NN  = N * N;
    localparam int IW  = $clog2(N);
    localparam int SHW = 5;

    localparam int COL_SHIFT      = 7;
    localparam int ROW_SHIFT_BASE = 20;
    localparam int BD_LOW         = 8;
    localparam int BD_HIGH        = 10;

    localparam int K64 = 64;
    localparam int K83 = 83;
    localparam int K36 = 36;
    localparam int K89 = 89;
    localparam int K75 = 75;
    localparam int K50 = 50;
    localparam int K18 = 18;

    typedef logic signed [W-1:0]  smp_t;
    typedef smp_t [N-1:0]         vec_t;
    typedef logic signed [AW-1:0] acc_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_COL  = 2'd1,
        PH_ROW  = 2'd2
    } phase_t;

    typedef struct packed {
        phase_t          ph;
        logic [IW-1:0]   idx;
    } step_t;

    localparam logic signed [AW:0] SAT_HI = (AW+1)'((1 << (W-1)) - 1);
    localparam logic signed [AW:0] SAT_LO = -SAT_HI - 1;

    function automatic smp_t round_sat(input acc_t v, input logic [SHW-1:0] sh);
        logic signed [AW:0] t;
        logic signed [AW:0] ofs;
        ofs = $signed({{AW{1'b0}}, 1'b1} << (sh - 1'b1));
        t   = $signed({v[AW-1], v}) + ofs;
        t   = t >>> sh;
        if (t > SAT_HI)
            return smp_t'(SAT_HI);
        else if (t < SAT_LO)
            return smp_t'(SAT_LO);
        else
            return smp_t'(t);
    endfunction

endpackage

// File: rtl/idct8_core.sv
module idct8_core
    import idct8_pkg::*;
(
    input  vec_t             x,
    input  logic [SHW-1:0]   sh,
    output vec_t             y
);

    acc_t xs [N];
    acc_t ev [4];
    acc_t od [4];
    acc_t ee_sum, ee_dif, eo_a, eo_b;

    always_comb begin
        for (int i = 0; i < N; i++)
            xs[i] = acc_t'($signed(x[i]));

        ee_sum = acc_t'(K64) * (xs[0] + xs[4]);
        ee_dif = acc_t'(K64) * (xs[0] - xs[4]);
        eo_a   = acc_t'(K83) * xs[2] + acc_t'(K36) * xs[6];
        eo_b   = acc_t'(K36) * xs[2] - acc_t'(K83) * xs[6];

        ev[0] = ee_sum + eo_a;
        ev[1] = ee_dif + eo_b;
        ev[2] = ee_dif - eo_b;
        ev[3] = ee_sum - eo_a;

        od[0] = acc_t'(K89) * xs[1] + acc_t'(K75) * xs[3]
              + acc_t'(K50) * xs[5] + acc_t'(K18) * xs[7];
        od[1] = acc_t'(K75) * xs[1] - acc_t'(K18) * xs[3]
              - acc_t'(K89) * xs[5] - acc_t'(K50) * xs[7];
        od[2] = acc_t'(K50) * xs[1] - acc_t'(K89) * xs[3]
              + acc_t'(K18) * xs[5] + acc_t'(K75) * xs[7];
        od[3] = acc_t'(K18) * xs[1] - acc_t'(K50) * xs[3]
              + acc_t'(K75) * xs[5] - acc_t'(K89) * xs[7];
    end

    for (genvar k = 0; k < N/2; k++) begin : g_comb
        assign y[k]       = round_sat(ev[k] + od[k], sh);
        assign y[N-1-k]   = round_sat(ev[k] - od[k], sh);
    end

endmodule

// File: rtl/idct8_tbuf.sv
module idct8_tbuf
    import idct8_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_col,
    input  vec_t            wr_data,
    input  logic [IW-1:0]   rd_row,
    output vec_t            rd_data
);

    vec_t mem [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < N; r++)
                mem[r] <= '0;
        end else if (wr_en) begin
            for (int r = 0; r < N; r++)
                mem[r][wr_col] <= wr_data[r];
        end
    end

    assign rd_data = mem[rd_row];

endmodule

// File: rtl/idct8_ctrl.sv
module idct8_ctrl
    import idct8_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output step_t  st,
    output logic   accept,
    output logic   done
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    assign accept = (st.ph == PH_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '{ph: PH_IDLE, idx: '0};
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st.ph)
                PH_IDLE: begin
                    if (start) begin
                        st.ph  <= PH_COL;
                        st.idx <= '0;
                    end
                end
                PH_COL: begin
                    if (st.idx == LAST) begin
                        st.ph  <= PH_ROW;
                        st.idx <= '0;
                    end else begin
                        st.idx <= st.idx + 1'b1;
                    end
                end
                PH_ROW: begin
                    if (st.idx == LAST) begin
                        st.ph  <= PH_IDLE;
                        st.idx <= '0;
                        done   <= 1'b1;
                    end else begin
                        st.idx <= st.idx + 1'b1;
                    end
                end
                default: st <= '{ph: PH_IDLE, idx: '0};
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_AFTER_ROW: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(st.ph) == PH_ROW && $past(st.idx) == LAST)); // R9

    AST_COL_TO_ROW: assert property (@(posedge clk) disable iff (rst)
        (st.ph == PH_COL && st.idx == LAST) |=> (st.ph == PH_ROW && st.idx == '0)); // R8

    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (st.ph == PH_COL && st.idx != LAST && start) |=> (st.ph == PH_COL)); // R10

endmodule

// File: rtl/idct8_2d.sv
module idct8_2d
    import idct8_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 bd_sel,
    input  logic [NN*W-1:0]      coef_in,
    output logic [NN*W-1:0]      res_out,
    output logic                 done
);

    step_t               st;
    logic                accept;
    logic [NN*W-1:0]     in_q;
    logic [NN*W-1:0]     res_q;
    logic                bd_q;
    vec_t                core_x;
    vec_t                core_y;
    vec_t                mid_row;
    logic [SHW-1:0]      sh;

    idct8_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .st     (st),
        .accept (accept),
        .done   (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q <= '0;
            bd_q <= 1'b0;
        end else if (accept) begin
            in_q <= coef_in;
            bd_q <= bd_sel;
        end
    end

    always_comb begin
        for (int r = 0; r < N; r++) begin
            if (st.ph == PH_ROW)
                core_x[r] = mid_row[r];
            else
                core_x[r] = in_q[W*(N*r + int'(st.idx)) +: W];
        end
        if (st.ph == PH_ROW)
            sh = SHW'(ROW_SHIFT_BASE - (bd_q ? BD_HIGH : BD_LOW));
        else
            sh = SHW'(COL_SHIFT);
    end

    idct8_core u_core (
        .x  (core_x),
        .sh (sh),
        .y  (core_y)
    );

    idct8_tbuf u_tbuf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (st.ph == PH_COL),
        .wr_col  (st.idx),
        .wr_data (core_y),
        .rd_row  (st.idx),
        .rd_data (mid_row)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (st.ph == PH_ROW) begin
            for (int c = 0; c < N; c++)
                res_q[W*(N*int'(st.idx) + c) +: W] <= core_y[c];
        end
    end

    assign res_out = res_q;

    AST_IN_HELD: assert property (@(posedge clk) disable iff (rst)
        (st.ph != PH_IDLE) |=> $stable(in_q)); // R10

    AST_BD_HELD: assert property (@(posedge clk) disable iff (rst)
        (st.ph != PH_IDLE) |=> $stable(bd_q)); // R11

    AST_RES_HELD: assert property (@(posedge clk) disable iff (rst)
        (st.ph != PH_ROW) |=> $stable(res_out)); // R9

endmodule

// File: tb/idct8_2d_tb.sv
module idct8_2d_tb;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          bd_sel;
    logic [1023:0] coef_in;
    logic [1023:0] res_out;
    logic          done;

    int total = 0;
    int bad   = 0;
    int blk   [64];
    int expv  [64];
    bit finished = 1'b0;

    always #4 clk = ~clk;

    idct8_2d u_dut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .bd_sel  (bd_sel),
        .coef_in (coef_in),
        .res_out (res_out),
        .done    (done)
    );

    function automatic int rs(input int v, input int s);
        int t;
        t = (v + (1 << (s - 1))) >>> s;
        if (t > 32767)  t = 32767;
        if (t < -32768) t = -32768;
        return t;
    endfunction

    task automatic tr8(input int x[8], input int s, output int y[8]);
        int e[4];
        int o[4];
        e[0] = 64*x[0] + 64*x[4] + 83*x[2] + 36*x[6];
        e[1] = 64*x[0] - 64*x[4] + 36*x[2] - 83*x[6];
        e[2] = 64*x[0] - 64*x[4] - 36*x[2] + 83*x[6];
        e[3] = 64*x[0] + 64*x[4] - 83*x[2] - 36*x[6];
        o[0] = 89*x[1] + 75*x[3] + 50*x[5] + 18*x[7];
        o[1] = 75*x[1] - 18*x[3] - 89*x[5] - 50*x[7];
        o[2] = 50*x[1] - 89*x[3] + 18*x[5] + 75*x[7];
        o[3] = 18*x[1] - 50*x[3] + 75*x[5] - 89*x[7];
        for (int k = 0; k < 4; k++) begin
            y[k]   = rs(e[k] + o[k], s);
            y[7-k] = rs(e[k] - o[k], s);
        end
    endtask

    task automatic model(input bit bd);
        int mid [64];
        int x[8];
        int y[8];
        for (int c = 0; c < 8; c++) begin
            for (int r = 0; r < 8; r++) x[r] = blk[r*8+c];
            tr8(x, 7, y);
            for (int r = 0; r < 8; r++) mid[r*8+c] = y[r];
        end
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) x[c] = mid[r*8+c];
            tr8(x, bd ? 10 : 12, y);
            for (int c = 0; c < 8; c++) expv[r*8+c] = y[c];
        end
    endtask

    task automatic load_blk();
        for (int i = 0; i < 64; i++) coef_in[16*i +: 16] = 16'(blk[i]);
    endtask

    task automatic run(input bit bd, output int lat);
        @(negedge clk);
        load_blk();
        bd_sel = bd;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        lat    = 1;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic cmp(input string req);
        int bi;
        bi = -1;
        total++;
        for (int i = 0; i < 64; i++)
            if (bi < 0 && $signed(res_out[16*i +: 16]) != expv[i]) bi = i;
        if (bi >= 0) begin
            bad++;
            $display("FAIL %s: idx %0d actual %0d expected %0d", req, bi,
                     $signed(res_out[16*bi +: 16]), expv[bi]);
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int ex);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, ex);
        end
    endtask

    task automatic clr();
        for (int i = 0; i < 64; i++) blk[i] = 0;
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lat;
        rst = 1'b1; start = 1'b0; bd_sel = 1'b0; coef_in = '0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(res_out == '0, "R1 res", int'(res_out[15:0]), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && res_out == '0, "R1 after", int'(done), 0);

        // DC block, closed-form: col gives 32, row gives 1 (bd8) or 2 (bd10)
        clr(); blk[0] = 64;
        run(1'b0, lat);
        chk(lat == 17, "R9 latency", lat, 17);
        for (int i = 0; i < 64; i++) expv[i] = 1;
        cmp("R2 R5 R6 dc bd8");
        run(1'b1, lat);
        for (int i = 0; i < 64; i++) expv[i] = 2;
        cmp("R6 dc bd10");

        // R9: result held after done while inputs change
        @(negedge clk);
        coef_in = {64{16'h1234}};
        repeat (5) @(negedge clk);
        cmp("R9 hold");

        // impulse sweep over all positions, both bit depths
        for (int b = 0; b < 2; b++) begin
            for (int p = 0; p < 64; p++) begin
                clr(); blk[p] = (p % 2 == 0) ? 1000 : -777;
                model(b[0]);
                run(b[0], lat);
                cmp(p % 2 == 0 ? "R2 R8 impulse" : "R3 R8 impulse");
            end
        end

        // random blocks
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < 64; i++)
                blk[i] = (n < 20) ? (int'($urandom_range(0, 4000)) - 2000)
                                  : int'($signed(16'($urandom)));
            model(n[0]);
            run(n[0], lat);
            cmp("R4 random");
        end

        // saturation corners
        for (int i = 0; i < 64; i++) blk[i] = 32767;
        model(1'b0); run(1'b0, lat); cmp("R7 all max");
        for (int i = 0; i < 64; i++) blk[i] = -32768;
        model(1'b1); run(1'b1, lat); cmp("R7 all min");
        for (int i = 0; i < 64; i++) blk[i] = (((i/8) + i) % 2 == 0) ? 32767 : -32768;
        model(1'b0); run(1'b0, lat); cmp("R7 checker");

        // R10/R11: restart mid-block with new data and bit depth is ignored
        for (int i = 0; i < 64; i++) blk[i] = (i * 37) % 501 - 250;
        model(1'b0);
        @(negedge clk);
        load_blk(); bd_sel = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        coef_in = {64{16'h0100}}; bd_sel = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 5;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 17, "R10 latency", lat, 17);
        cmp("R10 R11 restart ignored");
        lat = 0;
        repeat (30) begin
            @(negedge clk);
            if (done) lat++;
        end
        chk(lat == 0, "R10 no extra done", lat, 0);
        cmp("R10 result kept");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule